// File: doc/BRIEF.md
# Fractional-Modulus Rate Pulse Generator

This block produces a strobe that is one master-clock cycle wide and repeats at a programmable average rate. All of its timing comes from the master clock. The accumulator modulus is set to the master clock frequency in hertz, which need not be a power of two. The rate word is therefore the desired output frequency in hertz, and any ratio is possible, fractional ones included. When the ratio is fractional, the spacing between strobes varies by one clock (by two in dual-phase mode). The long-run average is still Fc·M/N.

The accumulator is signed, and its sign bit is the wrap test. In single-phase mode, a negative accumulator has the registered wrap value (N − M) added to it and a strobe is emitted. A non-negative accumulator has the rate subtracted. In dual-phase mode, a phase flag alternates the two operations. One cycle subtracts the rate. The next cycle adds N/2 if the accumulator is negative, and emits a strobe when it does. This keeps only a two-input add and a two-way choice in the accumulator feedback path. Rates above N/2 are clamped to N/2. The mode is captured while reset is held. The parameter `CLK_HZ` (N) must be even.

Top module: `frac_rate_strobe`

## Requirements
- R1: A synchronous reset clears the accumulator, the phase flag and the registered rate, and the strobe is low in the cycle after any clock edge that sees reset.
- R2: In single-phase mode, after settling with a steady effective rate M, the pulse count P over any T consecutive cycles satisfies |P·N − T·M| < N.
- R3: The strobe is never high on two consecutive cycles.
- R4: In single-phase mode with M > 0, the gap between consecutive strobes is ⌊N/M⌋ or ⌈N/M⌉ cycles.
- R5: In dual-phase mode, after settling, the pulse count over T cycles (T even) satisfies |P·N − T·M| < 2N.
- R6: In dual-phase mode, wraps occur only in the add phase. Gaps between strobes are even and equal 2·⌊(N/2)/M⌋ or that value plus 2.
- R7: A rate word of zero never produces a strobe.
- R8: A rate word above N/2 behaves exactly as N/2, which gives a strobe on every second cycle.
- R9: The rate word is registered before it reaches the accumulator. In single-phase mode, with the rate M > 0 held across the release of reset, the strobe is low after the first two clock edges following release and high after the third. A later change of the rate word governs the count once the design has settled.
- R10: The mode input (1 = dual-phase) is sampled only while reset is asserted. Changing it while running has no effect on the strobe pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 1 selects dual-phase mode, 0 single-phase; sampled during reset |
| rate_hz | input | RATE_W | Requested strobe rate in hertz |
| strobe | output | 1 | One-cycle pulse at the programmed average rate |

## Verification
The bench uses a modulus of 100 and sweeps every rate word from 0 to 60 in both modes. It checks the windowed pulse count against the arithmetic bound and checks every gap against the floor/ceiling spacing. A wrong wrap value or a missing clamp shifts the count by many pulses. A wrap test applied in the wrong phase produces odd gaps. The rate-zero and clamped rates catch a design that pulses from an idle accumulator or overflows at rates beyond N/2. The first strobe's cycle after reset exposes a missing rate register, and a mode flip while running exposes a mode input that is not latched.

// File: rtl/frs_pkg.sv
package frs_pkg;

  // Limit a requested rate to half the modulus.
  function automatic longint unsigned clamp_rate(longint unsigned req,
                                                 longint unsigned half);
    return (req > half) ? half : req;
  endfunction

  // Amount added back when the accumulator wraps in single-phase mode.
  function automatic longint unsigned wrap_amount(longint unsigned modulus,
                                                  longint unsigned rate);
    return modulus - rate;
  endfunction

endpackage

// File: rtl/frs_rate_stage.sv
module frs_rate_stage #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RATE_W = 26,
  parameter int AW     = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RATE_W-1:0]    rate_in,
  output logic signed [AW-1:0] rate_q,
  output logic signed [AW-1:0] wrap_q
);
  localparam longint unsigned MODULUS = longint'(CLK_HZ);
  localparam longint unsigned HALF    = MODULUS / 2;

  logic signed [AW-1:0] rate_c;
  logic signed [AW-1:0] wrap_c;

  always_comb begin
    rate_c = AW'(frs_pkg::clamp_rate(64'(rate_in), HALF));
    wrap_c = AW'(frs_pkg::wrap_amount(MODULUS,
                   frs_pkg::clamp_rate(64'(rate_in), HALF)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      wrap_q <= AW'(MODULUS);
    end else begin
      rate_q <= rate_c;
      wrap_q <= wrap_c;
    end
  end

  // R8
  rate_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_q + wrap_q) == AW'(MODULUS) && rate_q <= AW'(HALF));

endmodule

// File: rtl/frs_phase_ctl.sv
module frs_phase_ctl (
  input  logic clk,
  input  logic rst,
  output logic phase_b
);
  always_ff @(posedge clk) begin
    if (rst) phase_b <= 1'b0;
    else     phase_b <= ~phase_b;
  end

  // R6
  phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> phase_b != $past(phase_b));

endmodule

// File: rtl/frs_accum.sv
module frs_accum #(
  parameter int CLK_HZ = 50_000_000,
  parameter int AW     = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 two_mode,
  input  logic                 phase_b,
  input  logic signed [AW-1:0] rate_q,
  input  logic signed [AW-1:0] wrap_q,
  output logic                 wrap_evt,
  output logic                 pulse
);
  localparam logic signed [AW-1:0] N_S    = AW'(CLK_HZ);
  localparam logic signed [AW-1:0] HALF_S = AW'(CLK_HZ / 2);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_nxt;
  logic                 acc_neg;

  assign acc_neg = acc[AW-1];

  always_comb begin
    if (two_mode) begin
      wrap_evt = phase_b & acc_neg;
      if (phase_b) acc_nxt = acc_neg ? acc + HALF_S : acc;
      else         acc_nxt = acc - rate_q;
    end else begin
      wrap_evt = acc_neg;
      acc_nxt  = acc_neg ? acc + wrap_q : acc - rate_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else begin
      acc   <= acc_nxt;
      pulse <= wrap_evt;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pulse && acc == '0));

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    acc >= -HALF_S && acc < N_S);

  // R3
  pulse_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R6
  dual_phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (two_mode && wrap_evt) |-> phase_b);

  // R7
  zero_rate_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_q == '0 && !acc_neg) |=> !pulse);

endmodule

// File: rtl/frac_rate_strobe.sv
module frac_rate_strobe #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int RATE_W  = 26,
  parameter bit DUAL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_dual,
  input  logic [RATE_W-1:0] rate_hz,
  output logic              strobe
);
  localparam int MOD_W = $clog2(CLK_HZ + 1);
  localparam int AW    = MOD_W + 2;

  logic                 mode_q;
  logic                 phase_b;
  logic                 wrap_evt;
  logic signed [AW-1:0] rate_q;
  logic signed [AW-1:0] wrap_q;

  generate
    if (DUAL_EN) begin : g_mode
      always_ff @(posedge clk) begin
        if (rst) mode_q <= mode_dual;
      end
    end else begin : g_single
      assign mode_q = 1'b0;
    end
  endgenerate

  frs_rate_stage #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W), .AW(AW)) u_rate (
    .clk(clk), .rst(rst), .rate_in(rate_hz), .rate_q(rate_q), .wrap_q(wrap_q)
  );

  frs_phase_ctl u_phase (.clk(clk), .rst(rst), .phase_b(phase_b));

  frs_accum #(.CLK_HZ(CLK_HZ), .AW(AW)) u_acc (
    .clk(clk), .rst(rst), .two_mode(mode_q), .phase_b(phase_b),
    .rate_q(rate_q), .wrap_q(wrap_q), .wrap_evt(wrap_evt), .pulse(strobe)
  );

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));

endmodule

// File: tb/tb_frac_rate_strobe.sv
module tb_frac_rate_strobe;
  localparam int N      = 100;
  localparam int H      = N / 2;
  localparam int RW     = 8;
  localparam int T      = 400;
  localparam int SETTLE = 200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_dual = 1'b0;
  logic [RW-1:0] rate_hz = '0;
  logic          strobe;

  int checks = 0;
  int fails  = 0;

  frac_rate_strobe #(.CLK_HZ(N), .RATE_W(RW), .DUAL_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .mode_dual(mode_dual), .rate_hz(rate_hz), .strobe(strobe)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit dual, input int rate);
    @(negedge clk);
    rst = 1'b1; mode_dual = dual; rate_hz = RW'(rate);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic bit gap_ok(input bit dual, input int m, input int gap);
    int lo, hi;
    if (!dual) begin
      lo = N / m; hi = (N + m - 1) / m;
      return gap == lo || gap == hi;
    end
    lo = 2 * (H / m); hi = lo + 2;
    return (gap % 2 == 0) && (gap == lo || gap == hi);
  endfunction

  // Program a rate, settle, then count pulses and gaps over T cycles.
  task automatic measure(input int m, input bit dual_rules);
    int me, p, last, bad_gap, dbl, diff, bound;
    bit prev;
    me = (m > H) ? H : m;
    p = 0; last = -1; bad_gap = 0; dbl = 0; prev = 1'b0;
    @(negedge clk);
    rate_hz = RW'(m);
    repeat (SETTLE) @(negedge clk);
    for (int i = 0; i < T; i++) begin
      @(negedge clk);
      if (strobe) begin
        p++;
        if (last >= 0 && !gap_ok(dual_rules, me, i - last)) bad_gap++;
        last = i;
      end
      if (strobe && prev) dbl++;
      prev = strobe;
    end
    diff  = p * N - T * me;
    bound = dual_rules ? 2 * N : N;
    if (dual_rules)
      check(diff > -bound && diff < bound, "R5", $sformatf("count rate=%0d", m), p, T * me / N);
    else
      check(diff > -bound && diff < bound, "R2/R9", $sformatf("count rate=%0d", m), p, T * me / N);
    if (me > 0) begin
      if (dual_rules) check(bad_gap == 0, "R6", $sformatf("bad gaps rate=%0d", m), bad_gap, 0);
      else            check(bad_gap == 0, "R4", $sformatf("bad gaps rate=%0d", m), bad_gap, 0);
    end else begin
      check(p == 0, "R7", "pulses at zero rate", p, 0);
    end
    check(dbl == 0, "R3", $sformatf("double-wide strobes rate=%0d", m), dbl, 0);
    if (m > H) check(p == T / 2, "R8", $sformatf("clamped count rate=%0d", m), p, T / 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: strobe low under reset
    repeat (3) @(negedge clk);
    check(strobe == 1'b0, "R1", "strobe during reset", strobe, 0);
    rst = 1'b0;

    // R7: idle rate after reset
    begin
      int p = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (strobe) p++;
      end
      check(p == 0, "R7", "pulses with rate 0 after reset", p, 0);
    end

    // R9: exact first-strobe latency with rate held across release
    do_reset(1'b0, 20);
    @(negedge clk); check(strobe == 1'b0, "R9", "edge1 strobe", strobe, 0);
    @(negedge clk); check(strobe == 1'b0, "R9", "edge2 strobe", strobe, 0);
    @(negedge clk); check(strobe == 1'b1, "R9", "edge3 strobe", strobe, 1);

    // R1: reset mid-run at max rate
    @(negedge clk); rate_hz = RW'(H);
    repeat (11) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); check(strobe == 1'b0, "R1", "strobe after mid-run reset", strobe, 0);
    @(negedge clk); check(strobe == 1'b0, "R1", "strobe held in reset", strobe, 0);
    rate_hz = '0;
    @(negedge clk); rst = 1'b0;

    // Single-phase sweep without intermediate reset (R2, R4, R7, R8, R9)
    for (int m = 0; m <= 60; m++) measure(m, 1'b0);

    // Dual-phase sweep (R5, R6, R7, R8)
    do_reset(1'b1, 0);
    for (int m = 0; m <= 60; m++) measure(m, 1'b1);

    // R10: mode flips while running are ignored
    do_reset(1'b0, 30);
    @(negedge clk); mode_dual = 1'b1;
    measure(30, 1'b0);
    measure(7, 1'b0);
    do_reset(1'b1, 30);
    @(negedge clk); mode_dual = 1'b0;
    measure(30, 1'b1);
    measure(7, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule